// File: doc/BRIEF.md
# Buffered Manchester Packet Serial Port

This block moves one fixed-size packet at a time between two local byte buffers and a single self-clocked serial wire. The host loads the transmit buffer over a simple byte-wide register bus and then sets a send bit. On the next boundary of the port's bit clock, the transmitter puts a frame on the line. The frame has an alternating preamble byte, a start-of-frame byte and then the packet. When the last bit has gone out, the hardware drops the send bit and raises a transmit interrupt.

To receive, the host sets a receive bit. The receiver picks up that request on the next bit-clock boundary and then hunts. It oversamples the line, locks onto the mid-bit transitions of the Manchester code and watches for the start-of-frame byte. After the match it stores the next packet's bits in the receive buffer. It then drops the receive bit and raises a receive interrupt. Both interrupts are levels that the host clears by writing ones to a status register.

The bit clock is a free-running divider of the system clock. One bit lasts `OVS` system clocks. The receiver samples at that same rate, which gives `OVS`-times oversampling.

Transmit states: TX_IDLE (line low, waits for a pending send at a bit tick), TX_PRE (eight preamble bits), TX_SFD (eight start-of-frame bits), TX_DATA (all packet bits) and TX_FIN (one cycle that reports completion, then back to TX_IDLE).

Receive states: RX_IDLE (waits for a pending receive at a bit tick), RX_HUNT (decodes bits into an 8-bit window until it equals 0xD5), RX_DATA (stores packet bits) and RX_FIN (one cycle that reports completion, then back to RX_IDLE).

Top module: `sp_port`

## Requirements
- R1: Address map with PKT_BYTES=16 (ADDR_W=6):
  - 0x00–0x0F are the transmit buffer bytes, readable and writable.
  - 0x10–0x1F are the receive buffer bytes, read-only.
  - 0x20 is control: bit0 = send pending, bit1 = receive pending. Writing 1 to a bit sets it and writing 0 has no effect.
  - 0x21 is status: bit0 = transmit done, bit1 = receive done.
  - Reads of a buffer byte return its stored value.
- R2: The line stays low whenever no send is pending. After a send is requested, the first mid-bit transition appears within 1.5 bit periods plus two clocks, because the request is taken at the next bit-clock tick.
- R3: When the frame's last bit ends, the hardware clears control bit0 and raises irq_tx (status bit0).
- R4: A frame consists of the following fields, in this order. Every byte is sent least-significant bit first.
  - The preamble byte 0x55.
  - The start-of-frame byte 0xD5.
  - The buffer bytes, from index 0 up.
- R5: Manchester coding with a bit period of OVS clocks. A 0 is high for the first half and low for the second. A 1 is low for the first half and high for the second.
- R6: With receive pending, the port stores the PKT_BYTES*8 bits that follow a 0xD5 pattern in the receive buffer, in the R4 order. It then clears control bit1 and raises irq_rx (status bit1).
- R7: Each interrupt holds high until 1 is written to its status bit: bit0 for transmit, bit1 for receive. Writing 0 leaves it set.
- R8: With no receive pending, a frame on the line does not change the receive buffer and raises no irq_rx.
- R9: Alternating bits without a start-of-frame match never complete a reception and are not stored. A preamble of any length before 0xD5 is accepted.
- R10: After reset, control and status read 0, both interrupts and the line are low, and both buffers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit period is OVS cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register/buffer address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| line_out | output | 1 | Manchester-coded transmit line |
| line_in | input | 1 | Manchester-coded receive line |
| irq_tx | output | 1 | Transmit-complete interrupt level |
| irq_rx | output | 1 | Receive-complete interrupt level |

## Verification
A transmit FSM state or bit counter that is off by one shows on line_out within one bit period, as a misplaced header bit or a broken mid-bit transition. It can also show as a shifted data byte. The decoder in the bench catches each of these on the first frame. A receive clock-recovery fault, a window fault or a byte-assembly fault shows only when the packet is read back from the receive buffer, about one frame time later. It appears as wrong bytes, or as a missing or early irq_rx. Stuck or lost control and status bits show when those registers are read right after the interrupts rise.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_PRE,
        TX_SFD,
        TX_DATA,
        TX_FIN
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HUNT,
        RX_DATA,
        RX_FIN
    } rx_state_e;

    localparam logic [7:0] PRE_PAT = 8'h55;
    localparam logic [7:0] SFD_PAT = 8'hD5;
endpackage

// File: rtl/sp_bitclk.sv
module sp_bitclk #(
    parameter int OVS  = 8,
    parameter int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            bit_tick
);
    localparam logic [PH_W-1:0] LAST = PH_W'(OVS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end

    assign bit_tick = (phase == LAST);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int PKT_BYTES = 16,
    parameter int OVS       = 8,
    parameter int PH_W      = $clog2(OVS),
    parameter int BIDX_W    = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [PH_W-1:0]   phase,
    input  logic              req,
    output logic [BIDX_W-1:0] byte_idx,
    input  logic [7:0]        byte_in,
    output logic              line,
    output logic              done
);
    localparam int PKT_BITS = PKT_BYTES * 8;
    localparam int IDX_W    = $clog2(PKT_BITS);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(PKT_BITS - 1);
    localparam logic [PH_W-1:0]  HALF     = PH_W'(OVS / 2);

    tx_state_e        st, nxt;
    logic [IDX_W-1:0] cnt;
    logic             cur_bit;
    logic             active;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TX_IDLE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (st == TX_IDLE || st == TX_FIN) begin
                cnt <= '0;
            end else if (bit_tick) begin
                cnt <= (nxt != st) ? '0 : cnt + IDX_W'(1);
            end
        end
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE: if (bit_tick && req)                          nxt = TX_PRE;
            TX_PRE:  if (bit_tick && cnt[2:0] == 3'd7)             nxt = TX_SFD;
            TX_SFD:  if (bit_tick && cnt[2:0] == 3'd7)             nxt = TX_DATA;
            TX_DATA: if (bit_tick && cnt == LAST_BIT)              nxt = TX_FIN;
            TX_FIN:                                                nxt = TX_IDLE;
            default:                                               nxt = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cur_bit = 1'b0;
        active  = 1'b0;
        unique case (st)
            TX_PRE:  begin cur_bit = PRE_PAT[cnt[2:0]]; active = 1'b1; end
            TX_SFD:  begin cur_bit = SFD_PAT[cnt[2:0]]; active = 1'b1; end
            TX_DATA: begin cur_bit = byte_in[cnt[2:0]]; active = 1'b1; end
            default: begin cur_bit = 1'b0;              active = 1'b0; end
        endcase
        line     = active && ((phase < HALF) ? ~cur_bit : cur_bit);
        done     = (st == TX_FIN);
        byte_idx = cnt[IDX_W-1:3];
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int PKT_BYTES = 16,
    parameter int OVS       = 8,
    parameter int BIDX_W    = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              req,
    input  logic              line_in,
    output logic              wr_en,
    output logic [BIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data,
    output logic              done
);
    localparam int PKT_BITS = PKT_BYTES * 8;
    localparam int IDX_W    = $clog2(PKT_BITS);
    localparam int BLANK    = (OVS * 3) / 4;
    localparam int BL_W     = $clog2(OVS + 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(PKT_BITS - 1);

    rx_state_e        st, nxt;
    logic [2:0]       sync;
    logic [BL_W-1:0]  blank;
    logic [7:0]       win;
    logic [7:0]       sh;
    logic [IDX_W-1:0] cnt;
    logic             edge_seen;
    logic             bit_ok;
    logic             bit_val;
    logic [7:0]       win_next;

    assign edge_seen = sync[1] ^ sync[2];
    assign bit_val   = sync[1];
    assign bit_ok    = edge_seen && (blank == '0) &&
                       (st == RX_HUNT || st == RX_DATA);
    assign win_next  = {bit_val, win[7:1]};

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            sync    <= '0;
            blank   <= '0;
            win     <= '0;
            sh      <= '0;
            cnt     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            st   <= nxt;
            sync <= {sync[1:0], line_in};

            if (st == RX_IDLE) begin
                blank <= '0;
            end else if (bit_ok) begin
                blank <= BL_W'(BLANK);
            end else if (blank != '0) begin
                blank <= blank - BL_W'(1);
            end

            if (st != RX_HUNT) begin
                win <= '0;
            end else if (bit_ok) begin
                win <= win_next;
            end

            if (st != RX_DATA) begin
                cnt <= '0;
            end else if (bit_ok) begin
                cnt <= cnt + IDX_W'(1);
                sh  <= {bit_val, sh[7:1]};
            end

            wr_en   <= (st == RX_DATA) && bit_ok && (cnt[2:0] == 3'd7);
            wr_idx  <= cnt[IDX_W-1:3];
            wr_data <= {bit_val, sh[7:1]};
        end
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE: if (bit_tick && req)                 nxt = RX_HUNT;
            RX_HUNT: if (bit_ok && win_next == SFD_PAT)   nxt = RX_DATA;
            RX_DATA: if (bit_ok && cnt == LAST_BIT)       nxt = RX_FIN;
            RX_FIN:                                       nxt = RX_IDLE;
            default:                                      nxt = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done = (st == RX_FIN);
    end
endmodule

// File: rtl/sp_port.sv
module sp_port #(
    parameter int PKT_BYTES = 16,
    parameter int OVS       = 8,
    parameter int ADDR_W    = $clog2(2 * PKT_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              line_out,
    input  logic              line_in,
    output logic              irq_tx,
    output logic              irq_rx
);
    // PKT_BYTES must be a power of two: buffer index is the low address bits
    localparam int BIDX_W = $clog2(PKT_BYTES);
    localparam int PH_W   = $clog2(OVS);
    localparam logic [ADDR_W-1:0] A_RXB  = ADDR_W'(PKT_BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * PKT_BYTES);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * PKT_BYTES + 1);

    logic [7:0]        tx_buf [PKT_BYTES];
    logic [7:0]        rx_buf [PKT_BYTES];
    logic              send_q, recv_q;
    logic              tx_flag, rx_flag;
    logic              wr_ctrl, wr_stat, wr_txb;
    logic [PH_W-1:0]   phase;
    logic              bit_tick;
    logic [BIDX_W-1:0] tx_idx;
    logic              tx_done, rx_done;
    logic              rx_we;
    logic [BIDX_W-1:0] rx_widx;
    logic [7:0]        rx_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_txb  = bus_wr && (bus_addr < A_RXB);

    sp_bitclk #(.OVS(OVS)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .bit_tick (bit_tick)
    );

    sp_tx #(.PKT_BYTES(PKT_BYTES), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .phase    (phase),
        .req      (send_q),
        .byte_idx (tx_idx),
        .byte_in  (tx_buf[tx_idx]),
        .line     (line_out),
        .done     (tx_done)
    );

    sp_rx #(.PKT_BYTES(PKT_BYTES), .OVS(OVS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .req      (recv_q),
        .line_in  (line_in),
        .wr_en    (rx_we),
        .wr_idx   (rx_widx),
        .wr_data  (rx_wdata),
        .done     (rx_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PKT_BYTES; i++) begin
                tx_buf[i] <= '0;
                rx_buf[i] <= '0;
            end
        end else begin
            if (wr_txb) tx_buf[bus_addr[BIDX_W-1:0]] <= bus_wdata;
            if (rx_we)  rx_buf[rx_widx] <= rx_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_q  <= 1'b0;
            recv_q  <= 1'b0;
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
        end else begin
            if (wr_ctrl && bus_wdata[0]) send_q <= 1'b1;
            if (tx_done)                 send_q <= 1'b0;
            if (wr_ctrl && bus_wdata[1]) recv_q <= 1'b1;
            if (rx_done)                 recv_q <= 1'b0;
            if (wr_stat && bus_wdata[0]) tx_flag <= 1'b0;
            if (tx_done)                 tx_flag <= 1'b1;
            if (wr_stat && bus_wdata[1]) rx_flag <= 1'b0;
            if (rx_done)                 rx_flag <= 1'b1;
        end
    end

    always_comb begin
        if (bus_addr < A_RXB) begin
            bus_rdata = tx_buf[bus_addr[BIDX_W-1:0]];
        end else if (bus_addr < A_CTRL) begin
            bus_rdata = rx_buf[bus_addr[BIDX_W-1:0]];
        end else if (bus_addr == A_CTRL) begin
            bus_rdata = {6'b0, recv_q, send_q};
        end else if (bus_addr == A_STAT) begin
            bus_rdata = {6'b0, rx_flag, tx_flag};
        end else begin
            bus_rdata = 8'h00;
        end
    end

    assign irq_tx = tx_flag;
    assign irq_rx = rx_flag;
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stat,
    input logic [1:0] wd2,
    input logic       line_out,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       send_q,
    input logic       recv_q
);
    // R2: quiet line while nothing is pending
    p_quiet_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !send_q |-> !line_out);

    // R3: completion clears the send bit
    p_send_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> !send_q);

    // R6: completion clears the receive bit
    p_recv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> !recv_q);

    // R7: interrupt levels persist until cleared by a 1
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !(wr_stat && wd2[0])) |=> irq_tx);

    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !(wr_stat && wd2[1])) |=> irq_rx);

    // R8: a receive interrupt needs an armed receiver
    p_rx_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(recv_q));
endmodule

bind sp_port sp_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr_stat),
    .wd2      (bus_wdata[1:0]),
    .line_out (line_out),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx),
    .send_q   (send_q),
    .recv_q   (recv_q)
);

// File: tb/sim_sp_port.sv
module sim_sp_port;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_BYTES  = 16;
    localparam int OVS        = 8;
    localparam int ADDR_W     = 6;
    localparam int NBITS      = PKT_BYTES * 8 + 16;
    localparam logic [ADDR_W-1:0] A_CTRL = 6'h20;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h21;
    localparam int NVEC = 4;
    localparam logic [127:0] PATS [NVEC] = '{
        128'h0,
        {128{1'b1}},
        128'h0123456789ABCDEF_FEDCBA9876543210,
        128'hD5D5D5D5D5D5D5D5_D5D5D5D5D5D5D5D5
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;
    logic              line_out;
    logic              line_in;
    logic              irq_tx, irq_rx;
    logic              use_loop;
    logic              bench_line;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign line_in = use_loop ? line_out : bench_line;

    sp_port #(.PKT_BYTES(PKT_BYTES), .OVS(OVS)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .line_out  (line_out),
        .line_in   (line_in),
        .irq_tx    (irq_tx),
        .irq_rx    (irq_rx)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read_buf(input int base, output logic [127:0] v);
        logic [7:0] b;
        for (int i = 0; i < PKT_BYTES; i++) begin
            bus_read(ADDR_W'(base + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic load_tx(input logic [127:0] p);
        for (int i = 0; i < PKT_BYTES; i++) bus_write(ADDR_W'(i), p[8*i +: 8]);
    endtask

    task automatic decode_tx(output logic [NBITS-1:0] bits, output bit mh_ok,
                             output int lat);
        logic [NBITS-1:0] fh;
        lat = 0;
        mh_ok = 1'b1;
        bits = '0;
        fh = '0;
        while (!line_out && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        for (int k = 0; k < NBITS; k++) begin
            bits[k] = line_out;
            if (k > 0 && fh[k] != ~bits[k]) mh_ok = 1'b0;
            repeat (OVS / 2) @(negedge clk);
            if (k < NBITS - 1) fh[k+1] = line_out;
            repeat (OVS / 2) @(negedge clk);
        end
    endtask

    task automatic wait_irq(input bit rx_side, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if ((rx_side ? irq_rx : irq_tx) == 1'b1) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic bench_bit(input logic b);
        bench_line = ~b;
        repeat (OVS / 2) @(negedge clk);
        bench_line = b;
        repeat (OVS / 2) @(negedge clk);
    endtask

    task automatic bench_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) bench_bit(v[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]       r;
        logic [127:0]     v;
        logic [NBITS-1:0] bits;
        bit               mh_ok, seen;
        int               lat;
        logic [127:0]     last_rx;
        logic [127:0]     p_bench;

        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        use_loop = 1'b1; bench_line = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(irq_tx == 1'b0, "R10 irq_tx after reset", 128'(irq_tx), 0);
        check(irq_rx == 1'b0, "R10 irq_rx after reset", 128'(irq_rx), 0);
        check(line_out == 1'b0, "R10 line after reset", 128'(line_out), 0);
        bus_read(A_CTRL, r);
        check(r == 8'h00, "R10 control after reset", 128'(r), 0);
        bus_read(A_STAT, r);
        check(r == 8'h00, "R10 status after reset", 128'(r), 0);
        read_buf(PKT_BYTES, v);
        check(v == '0, "R10 rx buffer after reset", v, 0);
        read_buf(0, v);
        check(v == '0, "R10 tx buffer after reset", v, 0);

        // table walk: loopback frames
        for (int n = 0; n < NVEC; n++) begin
            load_tx(PATS[n]);
            read_buf(0, v);
            check(v == PATS[n], "R1 tx buffer read back", v, PATS[n]);
            bus_write(A_CTRL, 8'h02);
            bus_read(A_CTRL, r);
            check(r == 8'h02, "R1 control shows receive pending", 128'(r), 2);
            bus_write(A_CTRL, 8'h01);
            decode_tx(bits, mh_ok, lat);
            check(lat <= (3 * OVS) / 2 + 2, "R2 start latency", 128'(lat),
                  128'((3 * OVS) / 2 + 2));
            check(bits[15:0] == 16'hD555, "R4 preamble and start-of-frame",
                  128'(bits[15:0]), 128'h D555);
            check(bits[NBITS-1:16] == PATS[n], "R4 data order on line",
                  bits[NBITS-1:16], PATS[n]);
            check(mh_ok, "R5 half-bit inversion", 128'(mh_ok), 1);
            wait_irq(1'b0, seen);
            check(seen, "R3 irq_tx raised", 128'(seen), 1);
            wait_irq(1'b1, seen);
            check(seen, "R6 irq_rx raised", 128'(seen), 1);
            bus_read(A_CTRL, r);
            check(r == 8'h00, "R3 R6 control cleared by hardware", 128'(r), 0);
            read_buf(PKT_BYTES, v);
            check(v == PATS[n], "R6 received packet", v, PATS[n]);
            bus_write(A_STAT, 8'h00);
            bus_read(A_STAT, r);
            check(r == 8'h03, "R7 write 0 leaves status", 128'(r), 3);
            bus_write(A_STAT, 8'h01);
            bus_read(A_STAT, r);
            check(r == 8'h02 && !irq_tx && irq_rx, "R7 clear transmit bit only",
                  128'(r), 2);
            bus_write(A_STAT, 8'h02);
            bus_read(A_STAT, r);
            check(r == 8'h00 && !irq_rx, "R7 clear receive bit", 128'(r), 0);
        end
        last_rx = PATS[NVEC-1];

        // R8: frame while receiver not armed
        load_tx(128'hA5A5_0F0F_1234_5678_9ABC_DEF0_CAFE_0001);
        bus_write(A_CTRL, 8'h01);
        wait_irq(1'b0, seen);
        check(seen, "R3 irq_tx on unarmed frame", 128'(seen), 1);
        repeat (4 * OVS) @(negedge clk);
        check(irq_rx == 1'b0, "R8 no irq_rx when unarmed", 128'(irq_rx), 0);
        read_buf(PKT_BYTES, v);
        check(v == last_rx, "R8 rx buffer untouched", v, last_rx);
        bus_read(A_STAT, r);
        check(r == 8'h01, "R8 status only transmit done", 128'(r), 1);
        bus_write(A_STAT, 8'h03);

        // R9: hunting with bench-driven line
        use_loop = 1'b0;
        bus_write(A_CTRL, 8'h02);
        repeat (2 * OVS) @(negedge clk);
        for (int i = 0; i < 40; i++) bench_bit(i[0] ? 1'b0 : 1'b1);
        bench_line = 1'b0;
        repeat (30) @(negedge clk);
        check(irq_rx == 1'b0, "R9 alternating bits do not complete", 128'(irq_rx), 0);
        bus_read(A_CTRL, r);
        check(r == 8'h02, "R9 receiver still hunting", 128'(r), 2);
        read_buf(PKT_BYTES, v);
        check(v == last_rx, "R9 preamble not stored", v, last_rx);

        p_bench = 128'h55D5_55D5_00FF_8001_7E3C_C3A5_5AF0_0F11;
        for (int i = 0; i < 6; i++) bench_bit(i[0] ? 1'b0 : 1'b1);
        bench_byte(8'hD5);
        for (int i = 0; i < PKT_BYTES; i++) bench_byte(p_bench[8*i +: 8]);
        bench_line = 1'b0;
        wait_irq(1'b1, seen);
        check(seen, "R9 long preamble then frame completes", 128'(seen), 1);
        read_buf(PKT_BYTES, v);
        check(v == p_bench, "R6 R9 bench frame stored", v, p_bench);
        bus_read(A_CTRL, r);
        check(r == 8'h00, "R6 receive bit cleared", 128'(r), 0);
        check(line_out == 1'b0, "R2 line low with no send pending", 128'(line_out), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule